// File: doc/BRIEF.md
# Configuration Security Policy Controller

This block decides, cycle by cycle, which sensitive configuration operations a programmable device may carry out. It follows the life of a loaded configuration from an empty device, through loading and integrity verification, into operation and back out again. Along the way it records whether the running design arrived as an encrypted stream. When a stream is encrypted it closes the debug and modification paths. It also forces configuration memory to be wiped before such a load and after it is removed.

Four operations are requested through a request/grant pair each: readback, partial reconfiguration, warm reload and decryptor use. A grant is combinational on the request. The loader reports load start (with an encrypted flag), load completion and the result of the integrity check over decrypted data. A tamper sensor or an attempt to reach the key store moves the block at once into a zeroize state, which wipes keys and configuration. Every clear command stays asserted until the memory controller acknowledges it. A sticky status bit records that keys were erased, and only a key-program event lowers it.

Top module: `cfgsec_ctrl`

## Requirements
- R1: While the state output equals 5 (running an encrypted configuration), a readback request (bit 0 of the request vector) is never granted.
- R2: While the state output equals 5, a partial reconfiguration request (bit 1) is never granted.
- R3: A warm reload request (bit 2) is granted only in state 4 (running a plain configuration), and only when the encrypted flag is low. The grant moves the block to state 2 (loading) on the next edge without a pre-clear. In state 5, warm reload requests and load starts are ignored.
- R4: A load start with the encrypted flag high in state 0 moves the block to state 1, where the configuration clear is held until the clear acknowledge arrives and the block then enters state 2. Unloading in state 5 moves to state 6, which again holds the configuration clear until acknowledged and then returns to state 0.
- R5: A tamper event or a key-store access attempt moves the block to state 7 on the next edge from any state, overriding every other transition. State 7 drives both the key clear and the configuration clear until acknowledged, then returns to state 0.
- R6: In state 3 (verify), an integrity result with the pass bit low moves the block to state 6 rather than state 5.
- R7: A decryptor request (bit 3) is granted only in state 2 during an encrypted load, and never after configuration completes.
- R8: No request is granted in states 1, 6 or 7.
- R9: In state 4, readback and partial reconfiguration requests are granted.
- R10: The keys-erased status rises on the edge that enters zeroization and stays high until a key-program pulse, which clears it on the next edge.
- R11: After reset the state output is 0, all grants, clears and status are low. A plain load passes 0 to 2 at start and 2 to 4 at completion, and unloading from 4 returns to 0 with no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start_i | input | 1 | Pulse: a new configuration load begins |
| load_enc_i | input | 1 | The stream being started is encrypted |
| load_done_i | input | 1 | Pulse: loader finished writing configuration |
| mac_done_i | input | 1 | Pulse: integrity result available |
| mac_ok_i | input | 1 | Integrity result passed (valid with mac_done_i) |
| unload_i | input | 1 | Pulse: remove the current configuration |
| tamper_i | input | 1 | Tamper event |
| key_access_i | input | 1 | Attempt to reach the key store |
| key_program_i | input | 1 | Pulse: keys were programmed anew |
| clear_done_i | input | 1 | Acknowledge of the active clear command |
| req_i | input | 4 | Requests: 0 readback, 1 partial, 2 warm reload, 3 decryptor |
| gnt_o | output | 4 | Grants, same bit order as req_i |
| cfg_clear_o | output | 1 | Command: clear configuration memory |
| key_clear_o | output | 1 | Command: clear key store |
| cfg_state_o | output | 3 | Current state code |
| enc_active_o | output | 1 | An encrypted configuration is running |
| keys_erased_o | output | 1 | Sticky keys-erased status |

## Verification
Grants are combinational, so the bench drives a request between edges and reads the grant a nanosecond later in the same cycle. The state code, the clear commands, the encrypted-active flag and the keys-erased bit all come from registers and change on the first rising edge after the stimulus. The bench therefore applies each strobe, waits one rising edge plus a short settle, removes the strobe and only then compares. The holding checks on clears wait a further edge with no acknowledge and confirm nothing moved.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_CLEAR_PRE = 3'd1,
    ST_LOADING   = 3'd2,
    ST_VERIFY    = 3'd3,
    ST_RUN_PLAIN = 3'd4,
    ST_RUN_ENC   = 3'd5,
    ST_CLEAR_POST= 3'd6,
    ST_ZEROIZE   = 3'd7
  } cs_state_e;

  localparam int OP_NUM  = 4;
  localparam int OP_RB   = 0;
  localparam int OP_PR   = 1;
  localparam int OP_WARM = 2;
  localparam int OP_DEC  = 3;

  // true while a clear command is outstanding
  function automatic logic is_clearing(cs_state_e st);
    return (st == ST_CLEAR_PRE) || (st == ST_CLEAR_POST) || (st == ST_ZEROIZE);
  endfunction

  // policy table: may operation `op` be granted now
  function automatic logic op_allowed(int op, cs_state_e st, logic enc_load, logic next_enc);
    logic ok;
    ok = 1'b0;
    if (!is_clearing(st)) begin
      case (op)
        OP_RB, OP_PR: ok = (st == ST_RUN_PLAIN);
        OP_WARM:      ok = (st == ST_RUN_PLAIN) && !next_enc;
        OP_DEC:       ok = (st == ST_LOADING) && enc_load;
        default:      ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/cfgsec_fsm.sv
module cfgsec_fsm
  import cfgsec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_start,
  input  logic      load_enc,
  input  logic      load_done,
  input  logic      mac_done,
  input  logic      mac_ok,
  input  logic      unload,
  input  logic      zeroize_req,
  input  logic      warm_go,
  input  logic      clear_done,
  output cs_state_e state,
  output logic      enc_load,
  output logic      cfg_clear,
  output logic      key_clear
);

  cs_state_e state_nx;
  logic      enc_load_nx;

  always_comb begin
    state_nx    = state;
    enc_load_nx = enc_load;
    if (zeroize_req) begin
      state_nx    = ST_ZEROIZE;
      enc_load_nx = 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (load_start) begin
          state_nx    = load_enc ? ST_CLEAR_PRE : ST_LOADING;
          enc_load_nx = load_enc;
        end
        ST_CLEAR_PRE: if (clear_done) state_nx = ST_LOADING;
        ST_LOADING: if (load_done) state_nx = enc_load ? ST_VERIFY : ST_RUN_PLAIN;
        ST_VERIFY: if (mac_done) state_nx = mac_ok ? ST_RUN_ENC : ST_CLEAR_POST;
        ST_RUN_PLAIN: begin
          if (unload) state_nx = ST_IDLE;
          else if (warm_go) begin
            state_nx    = ST_LOADING;
            enc_load_nx = 1'b0;
          end
        end
        ST_RUN_ENC: if (unload) state_nx = ST_CLEAR_POST;
        ST_CLEAR_POST, ST_ZEROIZE: if (clear_done) begin
          state_nx    = ST_IDLE;
          enc_load_nx = 1'b0;
        end
        default: state_nx = ST_ZEROIZE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      enc_load <= 1'b0;
    end else begin
      state    <= state_nx;
      enc_load <= enc_load_nx;
    end
  end

  assign cfg_clear = is_clearing(state);
  assign key_clear = (state == ST_ZEROIZE);

  // R5: zeroize wins over every other transition
  p_zero_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zeroize_req |=> (state == ST_ZEROIZE));

  // R4: an encrypted load only reaches LOADING through the pre-clear
  p_pre_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOADING && enc_load && $past(state) != ST_LOADING)
      |-> ($past(state) == ST_CLEAR_PRE));

  // R4: clear command held until acknowledged
  p_clear_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clear && !clear_done) |=> cfg_clear);

  // R6: failed integrity never reaches the encrypted run state
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VERIFY && mac_done && !mac_ok && !zeroize_req) |=> (state == ST_CLEAR_POST));

endmodule

// File: rtl/cfgsec_grant.sv
module cfgsec_grant
  import cfgsec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_NUM-1:0] req,
  input  cs_state_e         state,
  input  logic              enc_load,
  input  logic              next_enc,
  output logic [OP_NUM-1:0] gnt
);

  for (genvar g = 0; g < OP_NUM; g++) begin : g_op
    assign gnt[g] = req[g] && op_allowed(g, state, enc_load, next_enc);
  end

  // R1: no readback of an encrypted design
  p_no_rb_enc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_ENC) |-> !gnt[OP_RB]);

  // R2: no partial reconfiguration of an encrypted design
  p_no_pr_enc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_ENC) |-> !gnt[OP_PR]);

  // R7: decryptor locked once configured
  p_dec_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_ENC || state == ST_RUN_PLAIN) |-> !gnt[OP_DEC]);

  // R8: nothing granted while a clear is pending
  p_clear_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_clearing(state) |-> (gnt == '0));

endmodule

// File: rtl/cfgsec_keyflag.sv
module cfgsec_keyflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic erased
);

  always_ff @(posedge clk) begin
    if (!rst_n)       erased <= 1'b0;
    else if (set_evt) erased <= 1'b1;
    else if (clr_evt) erased <= 1'b0;
  end

  // R10: sticky until a key-program pulse
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (erased && !clr_evt) |=> erased);

  // R10: rises only from a zeroize event
  p_flag_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!erased && !set_evt) |=> !erased);

endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl
  import cfgsec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start_i,
  input  logic              load_enc_i,
  input  logic              load_done_i,
  input  logic              mac_done_i,
  input  logic              mac_ok_i,
  input  logic              unload_i,
  input  logic              tamper_i,
  input  logic              key_access_i,
  input  logic              key_program_i,
  input  logic              clear_done_i,
  input  logic [OP_NUM-1:0] req_i,
  output logic [OP_NUM-1:0] gnt_o,
  output logic              cfg_clear_o,
  output logic              key_clear_o,
  output logic [2:0]        cfg_state_o,
  output logic              enc_active_o,
  output logic              keys_erased_o
);

  cs_state_e         state;
  logic              enc_load;
  logic              zeroize_req;
  logic [OP_NUM-1:0] gnt;

  assign zeroize_req = tamper_i | key_access_i;

  cfgsec_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start_i),
    .load_enc   (load_enc_i),
    .load_done  (load_done_i),
    .mac_done   (mac_done_i),
    .mac_ok     (mac_ok_i),
    .unload     (unload_i),
    .zeroize_req(zeroize_req),
    .warm_go    (gnt[OP_WARM]),
    .clear_done (clear_done_i),
    .state      (state),
    .enc_load   (enc_load),
    .cfg_clear  (cfg_clear_o),
    .key_clear  (key_clear_o)
  );

  cfgsec_grant u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_i),
    .state    (state),
    .enc_load (enc_load),
    .next_enc (load_enc_i),
    .gnt      (gnt)
  );

  cfgsec_keyflag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(zeroize_req),
    .clr_evt(key_program_i),
    .erased (keys_erased_o)
  );

  assign gnt_o        = gnt;
  assign cfg_state_o  = state;
  assign enc_active_o = (state == ST_RUN_ENC);

  // R5: key clear always accompanied by configuration clear
  p_key_with_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    key_clear_o |-> cfg_clear_o);

endmodule

// File: tb/sim_cfgsec_ctrl.sv
`timescale 1ns/1ps
module sim_cfgsec_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_start_i = 0, load_enc_i = 0, load_done_i = 0;
  logic mac_done_i = 0, mac_ok_i = 0, unload_i = 0;
  logic tamper_i = 0, key_access_i = 0, key_program_i = 0, clear_done_i = 0;
  logic [3:0] req_i = '0;
  logic [3:0] gnt_o;
  logic cfg_clear_o, key_clear_o, enc_active_o, keys_erased_o;
  logic [2:0] cfg_state_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfgsec_ctrl u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one edge, then settle, then drop all strobes
  task automatic tick();
    @(posedge clk); #2;
    load_start_i = 0; load_done_i = 0; mac_done_i = 0; unload_i = 0;
    tamper_i = 0; key_access_i = 0; key_program_i = 0; clear_done_i = 0;
    req_i = '0;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) @(posedge clk); #2; rst_n = 1; #1;
    chk("R11 reset state", cfg_state_o, 0);
    chk("R11 reset grants", gnt_o, 0);
    chk("R11 reset clears", {cfg_clear_o, key_clear_o}, 0);
    chk("R11 reset status", {enc_active_o, keys_erased_o}, 0);
  endtask

  task automatic t_plain();
    load_start_i = 1; load_enc_i = 0; tick();
    chk("R11 plain start", cfg_state_o, 2);
    chk("R11 no clear on plain", cfg_clear_o, 0);
    load_done_i = 1; tick();
    chk("R11 plain running", cfg_state_o, 4);
    req_i = 4'b0011; #1;
    chk("R9 rb+pr granted", gnt_o, 3);
    req_i = 4'b1000; #1;
    chk("R7 decryptor denied in plain run", gnt_o, 0);
    req_i = 4'b0100; load_enc_i = 1; #1;
    chk("R3 warm denied for encrypted stream", gnt_o, 0);
    load_enc_i = 0; #1;
    chk("R3 warm granted", gnt_o, 4);
    tick();
    chk("R3 warm reload without preclear", cfg_state_o, 2);
    chk("R3 no clear on warm", cfg_clear_o, 0);
    load_done_i = 1; tick();
    unload_i = 1; tick();
    chk("R11 plain unload", cfg_state_o, 0);
  endtask

  task automatic t_enc();
    load_start_i = 1; load_enc_i = 1; tick();
    load_enc_i = 0;
    chk("R4 preclear state", cfg_state_o, 1);
    chk("R4 preclear command", cfg_clear_o, 1);
    req_i = 4'b1111; #1;
    chk("R8 denied during clear", gnt_o, 0);
    tick();
    chk("R4 preclear held", {cfg_state_o, cfg_clear_o}, {3'd1, 1'b1});
    clear_done_i = 1; tick();
    chk("R4 load after clear", cfg_state_o, 2);
    chk("R4 clear released", cfg_clear_o, 0);
    req_i = 4'b1000; #1;
    chk("R7 decryptor for encrypted load", gnt_o, 8);
    load_done_i = 1; tick();
    chk("R6 verify state", cfg_state_o, 3);
    mac_done_i = 1; mac_ok_i = 1; tick();
    chk("R6 pass to enc run", cfg_state_o, 5);
    chk("R11 enc active", enc_active_o, 1);
    req_i = 4'b0001; #1; chk("R1 readback denied", gnt_o, 0);
    req_i = 4'b0010; #1; chk("R2 partial denied", gnt_o, 0);
    req_i = 4'b0100; #1; chk("R3 warm denied in enc run", gnt_o, 0);
    req_i = 4'b1000; #1; chk("R7 decryptor locked", gnt_o, 0);
    load_start_i = 1; tick();
    chk("R3 load start ignored in enc run", cfg_state_o, 5);
    unload_i = 1; tick();
    chk("R4 postclear", {cfg_state_o, cfg_clear_o}, {3'd6, 1'b1});
    req_i = 4'b0011; #1; chk("R8 denied in postclear", gnt_o, 0);
    clear_done_i = 1; tick();
    chk("R4 back to idle", cfg_state_o, 0);
  endtask

  task automatic t_mac_fail();
    load_start_i = 1; load_enc_i = 1; tick(); load_enc_i = 0;
    clear_done_i = 1; tick();
    load_done_i = 1; tick();
    mac_done_i = 1; mac_ok_i = 0; tick();
    chk("R6 reject to postclear", cfg_state_o, 6);
    chk("R6 not enc active", enc_active_o, 0);
    chk("R6 clear on reject", cfg_clear_o, 1);
    clear_done_i = 1; tick();
    chk("R6 idle after reject", cfg_state_o, 0);
  endtask

  task automatic t_tamper();
    load_start_i = 1; tick(); load_done_i = 1; tick();
    tamper_i = 1; unload_i = 1; tick();
    chk("R5 tamper beats unload", cfg_state_o, 7);
    chk("R5 both clears", {cfg_clear_o, key_clear_o}, 3);
    chk("R10 erased set", keys_erased_o, 1);
    req_i = 4'b0011; #1; chk("R8 denied in zeroize", gnt_o, 0);
    tick();
    chk("R5 zeroize held", {cfg_state_o, key_clear_o}, {3'd7, 1'b1});
    clear_done_i = 1; tick();
    chk("R5 idle after zeroize", cfg_state_o, 0);
    chk("R10 erased sticky", keys_erased_o, 1);
    load_start_i = 1; load_enc_i = 1; tick(); load_enc_i = 0;
    key_access_i = 1; clear_done_i = 1; tick();
    chk("R5 key access beats clear ack", cfg_state_o, 7);
    clear_done_i = 1; tick();
    key_program_i = 1; tick();
    chk("R10 erased cleared by key program", keys_erased_o, 0);
    chk("R10 state unaffected", cfg_state_o, 0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_enc();
    t_mac_fail();
    t_tamper();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule